// File: doc/BRIEF.md
# Ready-Line Bus Handover Controller

This controller shares one memory bus between a processor and a video fetch engine. The processor cannot be stopped in the middle of a write. The video engine also has no way to drive the read/write strobe itself. For these two reasons the processor is warned a fixed three cycles before the video engine needs the bus. When a fetch request arrives, the ready line to the processor falls in the next cycle. The processor may complete any write cycles it still has queued, and at most three of these can run back to back. It stalls on its first read cycle. After the three warning cycles the owner select hands the bus lanes to the video engine for the requested number of fetch cycles. Ready and ownership then return to the processor together.

A request that arrives while a handover is already running lengthens the current video window; the warning period does not start again. The block also reports two things. It flags every cycle in which the processor is actually frozen on a read. It raises a protocol-violation flag whenever a write strobe appears in a cycle the video engine owns.

Top module: `hbc_ctrl`

## Requirements
- R1: After reset, `cpu_rdy` is 1, `bus_own` is 0 (processor owns the bus), `vid_gnt` is 0 and no request is pending.
- R2: A `vid_req` seen in cycle c while the bus is idle drives `cpu_rdy` low from cycle c+1. That is exactly three cycles before the first video cycle.
- R3: `bus_own` is 1 (video owns the bus) in cycles c+4 through c+3+N. N is the effective length: `vid_len` when it lies in 1..8, 1 when `vid_len` is 0, and 8 when `vid_len` is above 8.
- R4: In the cycle after the last video cycle, `cpu_rdy` returns to 1 and `bus_own` returns to 0 in that same cycle.
- R5: `vid_gnt` is a single-cycle pulse in the first video cycle of each ownership window and is 0 at all other times.
- R6: A `vid_req` in any cycle from c+1 to c+3+N adds its own effective length to the current window. No new warning period starts, and the video cycles stay contiguous.
- R7: `cpu_hold` is 1 exactly when `cpu_rdy` is 0 and `cpu_wr` is 0. A write cycle (`cpu_wr`=1) while ready is low therefore still proceeds.
- R8: `bus_viol` is 1 in exactly those cycles where `bus_own` is 1 and `cpu_wr` is 1.
- R9: `cpu_rdy` is never 1 in a cycle where the video engine owns the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_req | input | 1 | Video fetch request, sampled each cycle |
| vid_len | input | 4 | Requested fetch cycle count (effective 1..8) |
| cpu_wr | input | 1 | Processor drives a write in this cycle |
| cpu_rdy | output | 1 | Bus-available indication to the processor |
| bus_own | output | 1 | Owner select: 0 processor, 1 video engine |
| vid_gnt | output | 1 | Pulse in the first video-owned cycle |
| cpu_hold | output | 1 | Processor is frozen on a read this cycle |
| bus_viol | output | 1 | Write strobe seen in a video-owned cycle |

## Verification
The first sweep issues a single request for every `vid_len` code from 0 to 15. It checks that the warning period has a fixed length and that the window length follows the clamped count. It also checks that the window edges line up with the grant pulse and the return of ready. A mixed write/read pattern runs on `cpu_wr` through the same sweep. This separates held read cycles from write cycles that proceed, and shows violations only inside the video window. The second sweep sends an extending request at every cycle offset of the warning and video phases, for all pairs of lengths. It confirms that the combined window has no gaps and never restarts the warning. A reset in the middle of a window checks that the processor gets the bus back at once.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  localparam int LEAD_CYC = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_VID  = 2'd2
  } phase_t;

  function automatic int eff_len(input int raw, input int max_len);
    if (raw < 1) return 1;
    if (raw > max_len) return max_len;
    return raw;
  endfunction

  function automatic int sat_add(input int a, input int b, input int lim);
    int s;
    s = a + b;
    if (s > lim) return lim;
    if (s < 0) return 0;
    return s;
  endfunction

endpackage

// File: rtl/hbc_seq.sv
module hbc_seq
  import hbc_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LEN_W-1:0] len,
  output logic             rdy,
  output logic             own_vid,
  output logic             gnt
);
  localparam int LEAD_W = $clog2(LEAD_CYC + 1);
  localparam int CNT_LIM = (2 ** CNT_W) - 1;

  phase_t            phase;
  logic [LEAD_W-1:0] lead_cnt;
  logic [CNT_W-1:0]  rem;
  logic              first_q;

  logic [CNT_W-1:0]  add_len;
  logic [CNT_W-1:0]  rem_lead_nxt;
  logic [CNT_W-1:0]  rem_vid_nxt;
  logic              lead_done;

  always_comb begin
    add_len      = req ? CNT_W'(eff_len(int'(len), MAX_LEN)) : '0;
    rem_lead_nxt = CNT_W'(sat_add(int'(rem), int'(add_len), CNT_LIM));
    rem_vid_nxt  = CNT_W'(sat_add(int'(rem) - 1, int'(add_len), CNT_LIM));
    lead_done    = (phase == PH_LEAD) && (lead_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      lead_cnt <= '0;
      rem      <= '0;
      first_q  <= 1'b0;
    end else begin
      first_q <= lead_done;
      unique case (phase)
        PH_IDLE: begin
          if (req) begin
            phase    <= PH_LEAD;
            lead_cnt <= LEAD_W'(LEAD_CYC - 1);
            rem      <= add_len;
          end
        end
        PH_LEAD: begin
          rem <= rem_lead_nxt;
          if (lead_cnt == '0) phase <= PH_VID;
          else                lead_cnt <= lead_cnt - 1'b1;
        end
        PH_VID: begin
          rem <= rem_vid_nxt;
          if (rem_vid_nxt == '0) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign rdy     = (phase == PH_IDLE);
  assign own_vid = (phase == PH_VID);
  assign gnt     = own_vid && first_q;

  AST_LEAD_BEFORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_vid) |-> ($past(!rdy, 1) && $past(!rdy, 2) && $past(!rdy, 3))); // R2

  AST_RETURN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_vid) |-> rdy); // R4

  AST_GNT_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> (own_vid && !$past(own_vid))); // R5

  AST_VID_EXITS_TO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    own_vid |=> (own_vid || rdy)); // R6

endmodule

// File: rtl/hbc_guard.sv
module hbc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  input  logic own_vid,
  input  logic wr,
  output logic hold,
  output logic viol
);
  assign hold = !rdy && !wr;
  assign viol = own_vid && wr;

  AST_NO_RDY_WHILE_VID: assert property (@(posedge clk) disable iff (!rst_n)
    own_vid |-> !rdy); // R9

  AST_VIOL_NEEDS_LOW_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (!rdy && !hold)); // R8

  AST_HOLD_ONLY_WHEN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !viol); // R7

endmodule

// File: rtl/hbc_ctrl.sv
module hbc_ctrl
  import hbc_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vid_req,
  input  logic [LEN_W-1:0] vid_len,
  input  logic             cpu_wr,
  output logic             cpu_rdy,
  output logic             bus_own,
  output logic             vid_gnt,
  output logic             cpu_hold,
  output logic             bus_viol
);
  localparam int CNT_W = $clog2(MAX_LEN * (LEAD_CYC + 1) * 2 + 1);

  logic seq_rdy;
  logic seq_own;
  logic seq_gnt;

  hbc_seq #(
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (vid_req),
    .len     (vid_len),
    .rdy     (seq_rdy),
    .own_vid (seq_own),
    .gnt     (seq_gnt)
  );

  hbc_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy     (seq_rdy),
    .own_vid (seq_own),
    .wr      (cpu_wr),
    .hold    (cpu_hold),
    .viol    (bus_viol)
  );

  assign cpu_rdy = seq_rdy;
  assign bus_own = seq_own;
  assign vid_gnt = seq_gnt;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (cpu_rdy && !bus_own && !vid_gnt)); // R1

endmodule

// File: tb/hbc_ctrl_bench.sv
module hbc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vid_req = 1'b0;
  logic [3:0] vid_len = 4'd0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rdy, bus_own, vid_gnt, cpu_hold, bus_viol;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbc_ctrl u_hbc_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_req  (vid_req),
    .vid_len  (vid_len),
    .cpu_wr   (cpu_wr),
    .cpu_rdy  (cpu_rdy),
    .bus_own  (bus_own),
    .vid_gnt  (vid_gnt),
    .cpu_hold (cpu_hold),
    .bus_viol (bus_viol)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int clamp_len(input int raw);
    if (raw == 0) return 1;
    if (raw > 8) return 8;
    return raw;
  endfunction

  // expected outputs for relative cycle j, window of n video cycles
  task automatic chk_cycle(input int j, input int n, input bit wr);
    bit e_rdy, e_own, e_gnt;
    e_rdy = !(j >= 1 && j <= 3 + n);
    e_own = (j >= 4 && j <= 3 + n);
    e_gnt = (j == 4);
    chk("R2/R4 cpu_rdy", int'(cpu_rdy), int'(e_rdy));
    chk("R3/R6 bus_own", int'(bus_own), int'(e_own));
    chk("R5 vid_gnt", int'(vid_gnt), int'(e_gnt));
    chk("R7 cpu_hold", int'(cpu_hold), int'(!e_rdy && !wr));
    chk("R8 bus_viol", int'(bus_viol), int'(e_own && wr));
    if (e_own) chk("R9 rdy low in video", int'(cpu_rdy), 0);
  endtask

  initial begin
    @(negedge clk);
    #1;
    chk("R1 rdy in reset", int'(cpu_rdy), 1);
    chk("R1 own in reset", int'(bus_own), 0);
    chk("R1 gnt in reset", int'(vid_gnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 rdy after reset", int'(cpu_rdy), 1);
    chk("R1 own after reset", int'(bus_own), 0);

    // Sweep 1: single request, all length codes, mixed write pattern
    for (int len = 0; len < 16; len++) begin
      int n;
      n = clamp_len(len);
      for (int j = 0; j <= n + 6; j++) begin
        bit wr;
        @(negedge clk);
        wr = (((j * 5) + len) % 3) == 0;
        vid_req = (j == 0);
        vid_len = 4'(len);
        cpu_wr  = wr;
        #1;
        chk_cycle(j, n, wr);
      end
      vid_req = 1'b0;
    end

    // Sweep 2: extending request at every offset of lead and video phases
    for (int n1 = 1; n1 <= 8; n1++) begin
      for (int m = 1; m <= 8; m++) begin
        for (int d = 1; d <= 3 + n1; d++) begin
          for (int j = 0; j <= n1 + m + 5; j++) begin
            @(negedge clk);
            cpu_wr  = 1'b0;
            vid_req = (j == 0) || (j == d);
            vid_len = (j == d) ? 4'(m) : 4'(n1);
            #1;
            chk_cycle(j, n1 + m, 1'b0);
          end
          vid_req = 1'b0;
        end
      end
    end

    // Reset in the middle of a video window returns the bus at once
    @(negedge clk);
    vid_req = 1'b1;
    vid_len = 4'd8;
    @(negedge clk);
    vid_req = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk("R3 own before reset", int'(bus_own), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 rdy after mid reset", int'(cpu_rdy), 1);
    chk("R1 own after mid reset", int'(bus_own), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 idle after release", int'(cpu_rdy), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule